// File: doc/BRIEF.md
# Weighted Round-Robin Channel Scheduler

This block decides, cycle by cycle, which of several virtual-channel buffers may drive one shared physical output channel. Every buffer presents a request bit. Every buffer also has a programmable weight that is held inside the scheduler. The scheduler visits the buffers in a fixed cyclic order. A buffer that wins the channel keeps it for as many back-to-back cycles as its weight, provided it keeps requesting. The scan then continues with the buffer after it.

The grant is formed in the same cycle as the request vector. When the scan reaches a buffer that is idle or has a zero weight, the grant falls through to the next eligible buffer in that same cycle, so the channel never loses a cycle while any eligible buffer is waiting. Over time, each requesting buffer receives a share of the channel equal to its weight divided by the sum of the weights of the requesting buffers. Weights are written one buffer at a time through a small configuration port, normally while the channel is idle.

Top module: `wrr_channel_sched`

## Requirements
- R1: `grant` has at most one bit set in any cycle, and `grantValid` is high exactly when some bit of `grant` is set.
- R2: A grant is only ever given to a buffer whose `req` bit is high in that same cycle and whose weight is nonzero.
- R3: A buffer of weight w that wins the channel keeps the grant for w consecutive cycles as long as it keeps requesting. After the w-th cycle, the scan moves on to the buffer after it.
- R4: The scan order is index 0, 1, …, NUM_BUF-1, and then it wraps back to index 0.
- R5: Whenever at least one buffer is requesting with a nonzero weight, a grant is given in that cycle. Buffers that are skipped cost no cycle.
- R6: With weights 1, 2, 2, 1 on buffers 0 to 3 and all four requesting, the grant sequence is 0, 1, 1, 2, 2, 3, and it then repeats.
- R7: In a cycle with no request, no grant is given and the scan position is kept. The next search begins at the buffer that follows the last buffer granted.
- R8: If the granted buffer drops its request before its weight is used up, the rest of its burst is abandoned. The grant goes in that cycle to the next eligible buffer after it.
- R9: A buffer whose weight is 0 is never granted, even while it requests.
- R10: When `cfgWe` is high at a rising clock edge, the weight of buffer `cfgIdx` becomes `cfgWgt`. The new weight is used from the next cycle on.
- R11: After reset, all weights are 1, no burst is in progress, and the first search begins at buffer 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | NUM_BUF | Request bit for each buffer |
| cfgWe | input | 1 | Weight write strobe |
| cfgIdx | input | $clog2(NUM_BUF) | Buffer whose weight is written |
| cfgWgt | input | WGT_W | Weight value to write |
| grant | output | NUM_BUF | One-hot grant, all zero when idle |
| grantValid | output | 1 | High when a grant is given this cycle |

## Verification
With every buffer requesting under the unequal weights 1, 2, 2, 1, the bench shows whether burst lengths follow the weights and whether the scan wraps. A request pattern with a hole at the scan position separates a same-cycle fall-through from a scheduler that wastes a cycle on an idle buffer. Idle gaps, a request dropped in the middle of a burst, and a zero weight each check how the scan position is kept or advanced. Long runs of random requests, with weight rewrites during idle cycles, are compared cycle by cycle against a reference model to catch ordering slips that the directed cases do not reach.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  // datapath -> control: what the current state allows
  typedef struct packed {
    logic canHold;   // owner still has burst cycles and still requests
    logic found;     // search from the scan position hit an eligible buffer
  } sched_status_t;

  // control -> datapath: what to do this cycle
  typedef struct packed {
    logic holdOwner; // keep the current owner, consume one burst cycle
    logic takeNew;   // grant the searched buffer and load its burst
  } sched_strobe_t;
endpackage

// File: rtl/wrr_weight_bank.sv
module wrr_weight_bank #(
  parameter int NUM_BUF = 4,
  parameter int WGT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWe,
  input  logic [IDX_W-1:0]                cfgIdx,
  input  logic [WGT_W-1:0]                cfgWgt,
  output logic [NUM_BUF-1:0][WGT_W-1:0]   wgt
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wgt[i] <= WGT_W'(1);
      else if (cfgWe && (cfgIdx == IDX_W'(i)))
        wgt[i] <= cfgWgt;
    end
  end
endmodule

// File: rtl/wrr_datapath.sv
module wrr_datapath
  import wrr_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int WGT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_BUF-1:0]              req,
  input  logic [NUM_BUF-1:0][WGT_W-1:0]   wgt,
  input  sched_strobe_t                   strobe,
  output sched_status_t                   status,
  output logic [NUM_BUF-1:0]              grant,
  output logic                            grantValid
);
  logic [IDX_W-1:0]   startIdx;   // where the next search begins
  logic [IDX_W-1:0]   ownIdx;     // buffer holding the current burst
  logic [WGT_W-1:0]   left;       // burst cycles still owed to ownIdx
  logic [NUM_BUF-1:0] eligible;
  logic [IDX_W-1:0]   pick;
  logic               found;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_elig
    assign eligible[i] = req[i] && (wgt[i] != '0);
  end

  // rotating first-eligible search starting at startIdx
  always_comb begin
    int idx;
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_BUF; k++) begin
      idx = (int'(startIdx) + k) % NUM_BUF;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

  assign status.canHold = (left != '0) && eligible[ownIdx];
  assign status.found   = found;

  always_comb begin
    grant = '0;
    if (strobe.holdOwner)
      grant[ownIdx] = 1'b1;
    else if (strobe.takeNew)
      grant[pick] = 1'b1;
  end
  assign grantValid = strobe.holdOwner || strobe.takeNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startIdx <= '0;
      ownIdx   <= '0;
      left     <= '0;
    end else if (strobe.holdOwner) begin
      left <= left - WGT_W'(1);
    end else if (strobe.takeNew) begin
      ownIdx   <= pick;
      left     <= wgt[pick] - WGT_W'(1);
      startIdx <= (pick == IDX_W'(NUM_BUF - 1)) ? '0 : pick + IDX_W'(1);
    end else begin
      left <= '0;
    end
  end
endmodule

// File: rtl/wrr_ctrl.sv
module wrr_ctrl
  import wrr_pkg::*;
(
  input  sched_status_t status,
  output sched_strobe_t strobe
);
  // a live burst has priority; otherwise start a new one if anyone is eligible
  always_comb begin
    strobe.holdOwner = status.canHold;
    strobe.takeNew   = !status.canHold && status.found;
  end
endmodule

// File: rtl/wrr_channel_sched.sv
module wrr_channel_sched
  import wrr_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int WGT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] req,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [WGT_W-1:0]   cfgWgt,
  output logic [NUM_BUF-1:0] grant,
  output logic               grantValid
);
  logic [NUM_BUF-1:0][WGT_W-1:0] wgt;
  sched_status_t status;
  sched_strobe_t strobe;

  wrr_weight_bank #(.NUM_BUF(NUM_BUF), .WGT_W(WGT_W)) u_bank (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgWgt(cfgWgt), .wgt(wgt)
  );

  wrr_ctrl u_ctrl (.status(status), .strobe(strobe));

  wrr_datapath #(.NUM_BUF(NUM_BUF), .WGT_W(WGT_W)) u_dp (
    .clk(clk), .rstN(rstN), .req(req), .wgt(wgt), .strobe(strobe),
    .status(status), .grant(grant), .grantValid(grantValid)
  );
endmodule

// File: rtl/wrr_sched_checker.sv
module wrr_sched_checker #(
  parameter int NUM_BUF = 4,
  parameter int WGT_W   = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_BUF-1:0]            req,
  input logic [NUM_BUF-1:0][WGT_W-1:0] wgt,
  input logic [NUM_BUF-1:0]            grant,
  input logic                          grantValid
);
  logic [NUM_BUF-1:0] nonZero;
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_nz
    assign nonZero[i] = (wgt[i] != '0);
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  p_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grant != '0));
  p_only_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~req) == '0);
  p_zero_wgt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~nonZero) == '0);
  p_no_waste_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((req & nonZero) != '0) |-> grantValid);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (req == '0) |-> !grantValid);
endmodule

bind wrr_channel_sched wrr_sched_checker #(.NUM_BUF(NUM_BUF), .WGT_W(WGT_W)) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .wgt(wgt),
  .grant(grant), .grantValid(grantValid)
);

// File: tb/sim_wrr_channel_sched.sv
module sim_wrr_channel_sched;
  localparam int N       = 4;
  localparam int WW      = 4;
  localparam int IW      = $clog2(N);
  localparam int PERIOD  = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  req = '0;
  logic          cfgWe = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [WW-1:0] cfgWgt = '0;
  logic [N-1:0]  grant;
  logic          grantValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mW [N];
  int mStart, mOwn, mLeft;

  always #(PERIOD/2) clk = ~clk;

  wrr_channel_sched #(.NUM_BUF(N), .WGT_W(WW)) u0 (
    .clk(clk), .rstN(rstN), .req(req), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgWgt(cfgWgt), .grant(grant), .grantValid(grantValid)
  );

  // expected grant from the requirements; advances model state
  function automatic logic [N-1:0] modelStep(input logic [N-1:0] r);
    logic [N-1:0] g = '0;
    bit fnd = 0;
    int p = 0;
    if (mLeft != 0 && r[mOwn] && mW[mOwn] != 0) begin
      g[mOwn] = 1'b1;
      mLeft--;
    end else begin
      for (int k = 0; k < N; k++) begin
        int ix = (mStart + k) % N;
        if (!fnd && r[ix] && mW[ix] != 0) begin fnd = 1; p = ix; end
      end
      if (fnd) begin
        g[p] = 1'b1; mOwn = p; mLeft = mW[p] - 1; mStart = (p + 1) % N;
      end else mLeft = 0;
    end
    return g;
  endfunction

  task automatic cmp(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp || grantValid !== (exp != '0)) begin
      errors++;
      $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
               tag, got, grantValid, exp, (exp != '0));
    end
  endtask

  // one cycle: drive after falling edge, check before rising edge
  task automatic step(input logic [N-1:0] r, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    req = r; cfgWe = 1'b0;
    #1;
    e = modelStep(r);
    cmp(tag, grant, e);
  endtask

  task automatic setW(input int i, input int w);
    logic [N-1:0] e;
    @(negedge clk);
    req = '0; cfgWe = 1'b1; cfgIdx = IW'(i); cfgWgt = WW'(w);
    #1;
    e = modelStep('0);
    cmp("R10 idle during write", grant, e);
    mW[i] = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seq [6] = '{0, 1, 1, 2, 2, 3};
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) mW[i] = 1;
    mStart = 0; mOwn = 0; mLeft = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state, then unit weights starting from buffer 0
    step('0, "R11 no grant after reset");
    step(4'hF, "R11 first grant buffer 0");
    step(4'hF, "R4 order");
    step(4'hF, "R4 order");
    step(4'hF, "R4 order last");
    step(4'hF, "R4 wrap to 0");
    step('0, "R7 idle");

    // R10 + R6: weights 1,2,2,1; scan now at buffer 1, realign through B..D
    setW(0, 1); setW(1, 2); setW(2, 2); setW(3, 1);
    step(4'b1000, "R10 new weight D");
    step('0, "R7 idle");
    for (int c = 0; c < 12; c++) begin
      step(4'hF, "R6 sequence");
      checks++;
      if (grant !== (N'(1) << seq[c % 6])) begin
        errors++;
        $display("FAIL R6 grant=%b expected=%b", grant, N'(1) << seq[c % 6]);
      end
    end

    // R5: scan at A; A idle, B idle -> C in same cycle
    step(4'b1100, "R5 skip to C");
    step(4'b1101, "R5 C burst");
    step(4'b1101, "R5 D");
    step(4'b1101, "R4 wrap A");

    // R3: long burst for buffer 0
    setW(0, 4);
    step('0, "R7 idle");
    for (int c = 0; c < 10; c++) step(4'b0011, "R3 burst");

    // R8: drop request mid-burst
    setW(1, 3);
    step(4'b0111, "R8 pre");
    step(4'b0111, "R8 pre");
    step(4'b0101, "R8 drop");
    step(4'b0111, "R8 after");

    // R9: zero weight never granted
    setW(2, 0);
    for (int c = 0; c < 10; c++) step(4'hF, "R9 zero weight");
    step(4'b0100, "R9 only zero requester");

    // R7: idle keeps the scan position
    step('0, "R7 idle");
    step('0, "R7 idle");
    step(4'hF, "R7 resume");

    // random traffic, weights rewritten in idle cycles
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r = N'($urandom);
      if (r == '0 && ($urandom % 2) == 1)
        setW(int'($urandom % N), int'($urandom % (1 << WW)));
      else
        step(r, "R2 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule